// File: doc/BRIEF.md
# Recursive Quadrant-Split Unsigned Multiplier

This block multiplies two unsigned operands of width `N` and returns the full
`2N`-bit product without any clock or storage. `N` is a power of two and at
least 2. The structure is recursive. Each operand is cut into an upper half and
a lower half. Four half-width copies of the same block form the four cross
products. Three adders then merge those products in two stages.

The recursion stops at a 2x2 cell. That cell is built from AND terms and two
half adders. Each half adder is a three-in, three-out reversible-style gate
whose first input is tied low. In that mode the gate returns the carry, the sum
and one unused complement output.

The lowest `N/2` product bits come straight from the low-by-low partial product
and pass through no adder. A width that is not a power of two stops elaboration
with an error.

Top module: `quad_split_mul`

## Requirements
- R1: For every pair of unsigned operands, `q_o` equals `a_i * b_i` as a `2N`-bit unsigned value.
- R2: When either operand is zero, every bit of `q_o` is zero.
- R3: The final adder never produces a carry out of its `N + N/2` bits. With both operands all ones, `q_o` equals `(2^N - 1)^2`.
- R4: `q_o[N/2-1:0]` equals the low `N/2` bits of `a_i[N/2-1:0] * b_i[N/2-1:0]`.
- R5: The 2x2 base cell gives the exact 4-bit product for all 16 input pairs. The carry and sum of each of its half-adder gates are never both 1.
- R6: When one operand equals 1, `q_o` equals the other operand, zero-extended to `2N` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| q_o | output | 2N | Unsigned full-width product |

## Verification
Immediate assertions inside each level check several properties whenever the inputs settle:
- the final adder never carries out,
- a zero operand gives a zero product,
- each level's output matches the arithmetic product,
- the two outputs of every half-adder gate are never both set.

Other properties can only be shown by the bench's operand patterns:
- that all four quadrant products are routed to the correct halves,
- that the low quarter bypasses the adders,
- the corner values of all ones and one.

The bench covers these with exhaustive sweeps at widths 2, 4 and 8, and with seeded random and directed vectors at widths 16 and 32.

// File: rtl/qsm_pkg.sv
package qsm_pkg;

    // True when w is a power of two and at least 2.
    function automatic bit width_ok(input int unsigned w);
        return (w >= 2) && ((w & (w - 1)) == 0);
    endfunction

    // Result of one half-adder-mode gate evaluation.
    typedef struct packed {
        logic carry;
        logic sum;
    } ha_res_t;

endpackage

// File: rtl/qsm_rev_gate.sv
// Three-in, three-out reversible-style primitive:
//   p = x & ~y | y & z,  q = y ^ z,  r = ~z
module qsm_rev_gate (
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output logic p_o,
    output logic q_o,
    output logic r_o
);
    always_comb begin
        p_o = (x_i & ~y_i) | (y_i & z_i);
        q_o = y_i ^ z_i;
        r_o = ~z_i;
    end
endmodule

// File: rtl/qsm_half_add.sv
// Half adder built from the reversible primitive with its first input held low.
module qsm_half_add
    import qsm_pkg::*;
(
    input  logic u_i,
    input  logic v_i,
    output logic carry_o,
    output logic sum_o
);
    logic    garbage;
    ha_res_t res_d;

    qsm_rev_gate u_gate (
        .x_i (1'b0),
        .y_i (u_i),
        .z_i (v_i),
        .p_o (res_d.carry),
        .q_o (res_d.sum),
        .r_o (garbage)
    );

    assign carry_o = res_d.carry;
    assign sum_o   = res_d.sum;

    always_comb begin
        if (!$isunknown({u_i, v_i})) begin
            AST_HA_EXCLUSIVE: assert (!(res_d.carry && res_d.sum)); // R5
            AST_HA_GARBAGE:   assert (!(res_d.carry && garbage));   // R5
        end
    end
endmodule

// File: rtl/qsm_adder.sv
// Plain unsigned adder with carry-out.
module qsm_adder #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] total_d;

    always_comb begin
        total_d = {1'b0, x_i} + {1'b0, y_i};
    end

    assign sum_o  = total_d[W-1:0];
    assign cout_o = total_d[W];
endmodule

// File: rtl/qsm_base2.sv
// 2x2 base cell: AND terms and two half-adder gates.
module qsm_base2 (
    input  logic [1:0] a_i,
    input  logic [1:0] b_i,
    output logic [3:0] q_o
);
    logic t00, t01, t10, t11;
    logic mid_cy;
    logic bit1, bit2, bit3;

    always_comb begin
        t00 = a_i[0] & b_i[0];
        t01 = a_i[0] & b_i[1];
        t10 = a_i[1] & b_i[0];
        t11 = a_i[1] & b_i[1];
    end

    qsm_half_add u_ha_lo (
        .u_i     (t01),
        .v_i     (t10),
        .carry_o (mid_cy),
        .sum_o   (bit1)
    );

    qsm_half_add u_ha_hi (
        .u_i     (t11),
        .v_i     (mid_cy),
        .carry_o (bit3),
        .sum_o   (bit2)
    );

    assign q_o = {bit3, bit2, bit1, t00};

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            AST_BASE_PRODUCT: assert (q_o == 4'({2'b00, a_i} * {2'b00, b_i})); // R5
        end
    end
endmodule

// File: rtl/quad_split_mul.sv
// Recursive quadrant-split unsigned multiplier.
module quad_split_mul
    import qsm_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [2*N-1:0] q_o
);
    localparam int unsigned H = N / 2;
    localparam int unsigned P = 2 * N;

    generate
        if (!width_ok(N)) begin : g_bad_width
            $error("quad_split_mul: N must be a power of two >= 2");
        end

        if (N == 2) begin : g_leaf
            qsm_base2 u_base (
                .a_i (a_i),
                .b_i (b_i),
                .q_o (q_o)
            );
        end else begin : g_split
            logic [N-1:0]   pp_ll, pp_hl, pp_lh, pp_hh;
            logic [N-1:0]   cross_sum;
            logic           cross_cy;
            logic [N+H-1:0] stack_sum;
            logic           stack_cy;
            logic           final_cy;

            quad_split_mul #(.N(H)) u_ll (
                .a_i (a_i[H-1:0]), .b_i (b_i[H-1:0]), .q_o (pp_ll));
            quad_split_mul #(.N(H)) u_hl (
                .a_i (a_i[N-1:H]), .b_i (b_i[H-1:0]), .q_o (pp_hl));
            quad_split_mul #(.N(H)) u_lh (
                .a_i (a_i[H-1:0]), .b_i (b_i[N-1:H]), .q_o (pp_lh));
            quad_split_mul #(.N(H)) u_hh (
                .a_i (a_i[N-1:H]), .b_i (b_i[N-1:H]), .q_o (pp_hh));

            // Stage one: cross-product sum, and high product stacked over low upper half.
            qsm_adder #(.W(N)) u_cross (
                .x_i    (pp_hl),
                .y_i    (pp_lh),
                .sum_o  (cross_sum),
                .cout_o (cross_cy)
            );

            qsm_adder #(.W(N + H)) u_stack (
                .x_i    ({pp_hh, {H{1'b0}}}),
                .y_i    ({{N{1'b0}}, pp_ll[N-1:H]}),
                .sum_o  (stack_sum),
                .cout_o (stack_cy)
            );

            // Stage two: merge at weight 2^H.
            qsm_adder #(.W(N + H)) u_final (
                .x_i    (stack_sum),
                .y_i    ({{(H-1){1'b0}}, cross_cy, cross_sum}),
                .sum_o  (q_o[P-1:H]),
                .cout_o (final_cy)
            );

            assign q_o[H-1:0] = pp_ll[H-1:0];

            always_comb begin
                if (!$isunknown({a_i, b_i})) begin
                    AST_NO_OVERFLOW:   assert (!final_cy);                    // R3
                    AST_STACK_NO_CARRY: assert (!stack_cy);                   // R3
                    AST_LEVEL_PRODUCT: assert (q_o == P'({{N{1'b0}}, a_i} * {{N{1'b0}}, b_i})); // R1
                end
            end
        end
    endgenerate

    always_comb begin
        if (!$isunknown({a_i, b_i}) && ((a_i == '0) || (b_i == '0))) begin
            AST_ZERO_OPERAND: assert (q_o == '0); // R2
        end
    end
endmodule

// File: tb/quad_split_mul_tb.sv
module quad_split_mul_tb;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [1:0]  a2,  b2;   logic [3:0]  q2;
    logic [3:0]  a4,  b4;   logic [7:0]  q4;
    logic [7:0]  a8,  b8;   logic [15:0] q8;
    logic [15:0] a16, b16;  logic [31:0] q16;
    logic [31:0] a32, b32;  logic [63:0] q32;

    quad_split_mul #(.N(2))  u_dut2  (.a_i(a2),  .b_i(b2),  .q_o(q2));
    quad_split_mul #(.N(4))  u_dut4  (.a_i(a4),  .b_i(b4),  .q_o(q4));
    quad_split_mul #(.N(8))  u_dut   (.a_i(a8),  .b_i(b8),  .q_o(q8));
    quad_split_mul #(.N(16)) u_dut16 (.a_i(a16), .b_i(b16), .q_o(q16));
    quad_split_mul #(.N(32)) u_dut32 (.a_i(a32), .b_i(b32), .q_o(q32));

    function automatic logic [63:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
        return {32'd0, x} * {32'd0, y};
    endfunction

    function automatic string pick_req(input logic [31:0] x, input logic [31:0] y,
                                       input logic [31:0] ones);
        if (x == 0 || y == 0) return "R2";
        if (x == 1 || y == 1) return "R6";
        if (x == ones && y == ones) return "R3";
        return "R1";
    endfunction

    task automatic check(input string req, input int w,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s N=%0d actual=%0h expected=%0h", req, w, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic run16(input logic [15:0] x, input logic [15:0] y);
        @(posedge clk); a16 = x; b16 = y; step();
        check(pick_req(32'(x), 32'(y), 32'hFFFF), 16, 64'(q16), ref_mul(32'(x), 32'(y)));
    endtask

    task automatic run32(input logic [31:0] x, input logic [31:0] y);
        @(posedge clk); a32 = x; b32 = y; step();
        check(pick_req(x, y, 32'hFFFF_FFFF), 32, q32, ref_mul(x, y));
    endtask

    initial begin
        a2 = '0; b2 = '0; a4 = '0; b4 = '0; a8 = '0; b8 = '0;
        a16 = '0; b16 = '0; a32 = '0; b32 = '0;
        void'($urandom(32'h5EED_0042));
        step();
        // Idle state: zero operands everywhere give zero product (R2)
        check("R2", 8,  64'(q8),  64'd0);
        check("R2", 32, q32,      64'd0);

        // R5: base cell, every pair
        for (int x = 0; x < 4; x++) begin
            for (int y = 0; y < 4; y++) begin
                @(posedge clk); a2 = 2'(x); b2 = 2'(y); step();
                check("R5", 2, 64'(q2), ref_mul(32'(x), 32'(y)));
            end
        end

        // R1: width 4, every pair
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                @(posedge clk); a4 = 4'(x); b4 = 4'(y); step();
                check(pick_req(32'(x), 32'(y), 32'hF), 4, 64'(q4), ref_mul(32'(x), 32'(y)));
            end
        end

        // R1, R4: width 8, every pair; low quarter checked separately
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                @(posedge clk); a8 = 8'(x); b8 = 8'(y); step();
                check(pick_req(32'(x), 32'(y), 32'hFF), 8, 64'(q8), ref_mul(32'(x), 32'(y)));
                if ((x % 17) == 0) begin
                    logic [7:0] lowp;
                    lowp = 8'(x % 16) * 8'(y % 16);
                    check("R4", 8, 64'(q8[3:0]), 64'(lowp[3:0]));
                end
            end
        end

        // Directed corners at widths 16 and 32 (R2, R3, R6)
        run16(16'h0000, 16'hBEEF);
        run16(16'h0001, 16'hBEEF);
        run16(16'hFFFF, 16'hFFFF);
        run16(16'h8000, 16'h8000);
        run32(32'h0, 32'hFFFF_FFFF);
        run32(32'hDEAD_BEEF, 32'h1);
        run32(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run32(32'h0000_FFFF, 32'hFFFF_0000);

        // R1: seeded random
        for (int i = 0; i < 2000; i++) begin
            run16(16'($urandom), 16'($urandom));
            run32($urandom, $urandom);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule